// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block buffers 18-bit words between two free-running clock domains whose clocks may be unrelated or identical. A producer writes on its own clock when two enables of opposite polarity agree and the FIFO reports room. A consumer takes words from an output register on its own clock. The oldest word moves into that register without any request, and a valid flag reports when it holds data. A read is made by pulling one read enable and two output-qualifying enables low while that flag is high.

The write domain also reports two occupancy flags. One shows that more than half of the capacity is in use. The other shows that the FIFO is close to empty or close to full, with a parameter setting the margin. Occupancy counts every stored word, including the word waiting in the output register. Reset can arrive at any time with respect to either clock. It must be held across at least four rising edges of each clock, and while it is held every flag stays at its defined reset level.

Top module: `dcfifo_fwft`

## Requirements
- R1: Capacity is 64 words of 18 bits, counting the word in the output register. After 64 words have been accepted with no reads, `in_rdy` is low and further write attempts are discarded.
- R2: A word is accepted on a rising `wr_clk` edge only when `wr_en_hi` is 1, `wr_en_lo_n` is 0 and `in_rdy` is 1. Any other combination leaves the FIFO contents unchanged.
- R3: A read happens on a rising `rd_clk` edge only when `rd_en_n`, `oe_a_n` and `oe_b_n` are all 0 and `out_rdy` is 1. On a read, the output register takes the next stored word, or `out_rdy` falls if no word is stored.
- R4: When the output register is empty and a stored word is available, that word is loaded into the register and `out_rdy` rises, whatever the levels of the read and output enables. While no read takes place, `out_rdy` stays high and `rd_data` stays stable.
- R5: While `rst` is 1 (held for at least four edges of each clock), `in_rdy`, `out_rdy` and `half_full` are 0 and `almost_flag` is 1. No write is accepted during reset, and words stored before reset are discarded.
- R6: After `rst` is released, `in_rdy` rises within 4 rising `wr_clk` edges.
- R7: `half_full` is 1 exactly when 33 or more words are stored.
- R8: `almost_flag` is 1 exactly when the stored count is at most ALMOST_N (default 8) or at least 64 minus ALMOST_N.
- R9: Words leave in the order they were accepted, with no loss or duplication, including when writes and reads happen at the same time on clocks of unrelated periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset, asynchronous to both clocks |
| wr_clk | input | 1 | Write-domain clock |
| wr_en_hi | input | 1 | Write enable, active high |
| wr_en_lo_n | input | 1 | Write enable, active low |
| wr_data | input | 18 | Word to store |
| in_rdy | output | 1 | Room for at least one word (write domain) |
| half_full | output | 1 | 33 or more words stored (write domain) |
| almost_flag | output | 1 | Near-empty or near-full indication (write domain) |
| rd_clk | input | 1 | Read-domain clock |
| rd_en_n | input | 1 | Read enable, active low |
| oe_a_n | input | 1 | First read qualifier, active low |
| oe_b_n | input | 1 | Second read qualifier, active low |
| rd_data | output | 18 | Output register contents |
| out_rdy | output | 1 | Output register holds a valid word (read domain) |

## Verification
A write into storage and a read from the output register can fall in the same window. When that happens, the refill of the output register competes with the arrival of the new word through the pointer synchronizers. The bench provokes this by first loading about half the capacity. It then runs a writer task and a reader task in parallel on clocks of 10 ns and 14 ns, so that the edges of the two domains slide past each other. The result is judged by comparing every word read against a reference queue in acceptance order, and by checking that the flags return to their empty levels once the traffic has finished.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    // Write-domain status flags, registered together.
    typedef struct packed {
        logic in_rdy;
        logic half_full;
        logic almost;
    } wflags_t;

    localparam wflags_t WFLAGS_RST = '{in_rdy: 1'b0, half_full: 1'b0, almost: 1'b1};

    // Occupancy at which the half-full flag switches on.
    function automatic int half_level(input int depth);
        return depth / 2 + 1;
    endfunction

endpackage

// File: rtl/dcfifo_sync2.sv
module dcfifo_sync2 #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ram [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) ram[waddr] <= wdata;
    end

    assign rdata = ram[raddr];
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
module dcfifo_wr_ctrl
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int ALMOST_N = 8,
    localparam int PTR_W   = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_hi,
    input  logic             we_lo_n,
    input  logic [PTR_W-1:0] rgray_async,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] wgray,
    output logic             wen,
    output wflags_t          flags
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PTR_W-1:0] FULL_C = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] HF_C   = PTR_W'(half_level(DEPTH));
    localparam logic [PTR_W-1:0] LO_C   = PTR_W'(ALMOST_N);
    localparam logic [PTR_W-1:0] HI_C   = PTR_W'(DEPTH - ALMOST_N);

    // Reset stretcher: raw reset plus two trailing edges.
    logic [1:0] rst_q;
    logic       hold;

    always_ff @(posedge clk) rst_q <= {rst_q[0], rst};
    assign hold = rst | rst_q[0] | rst_q[1];

    logic [PTR_W-1:0] rgray_s, rbin, wptr_n, cnt_n;

    dcfifo_sync2 #(.W(PTR_W)) u_rsync (
        .clk (clk),
        .rst (hold),
        .d   (rgray_async),
        .q   (rgray_s)
    );

    always_comb begin
        for (int i = 0; i < PTR_W; i++) rbin[i] = ^(rgray_s >> i);
    end

    assign wen    = we_hi & ~we_lo_n & flags.in_rdy & ~hold;
    assign wptr_n = wptr + PTR_W'(wen);
    assign cnt_n  = wptr_n - rbin;

    always_ff @(posedge clk) begin
        if (hold) begin
            wptr  <= '0;
            wgray <= '0;
            flags <= WFLAGS_RST;
        end else begin
            wptr            <= wptr_n;
            wgray           <= wptr_n ^ (wptr_n >> 1);
            flags.in_rdy    <= (cnt_n != FULL_C);
            flags.half_full <= (cnt_n >= HF_C);
            flags.almost    <= (cnt_n <= LO_C) || (cnt_n >= HI_C);
        end
    end
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
module dcfifo_rd_ctrl #(
    parameter int DATA_W  = 18,
    parameter int ADDR_W  = 6,
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ren_n,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    input  logic [PTR_W-1:0]  wgray_async,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  cptr,
    output logic [PTR_W-1:0]  cgray,
    output logic              avail,
    output logic              fire,
    output logic              out_q,
    output logic [DATA_W-1:0] dout
);
    logic [1:0] rst_q;
    logic       hold;

    always_ff @(posedge clk) rst_q <= {rst_q[0], rst};
    assign hold = rst | rst_q[0] | rst_q[1];

    logic [PTR_W-1:0] wgray_s, wbin, fptr, cptr_n;
    logic             load;

    dcfifo_sync2 #(.W(PTR_W)) u_wsync (
        .clk (clk),
        .rst (hold),
        .d   (wgray_async),
        .q   (wgray_s)
    );

    always_comb begin
        for (int i = 0; i < PTR_W; i++) wbin[i] = ^(wgray_s >> i);
    end

    // fptr: next word to fetch from storage; cptr: words handed to the consumer.
    assign raddr  = fptr[ADDR_W-1:0];
    assign avail  = (fptr != wbin);
    assign fire   = out_q & ~ren_n & ~oe_a_n & ~oe_b_n & ~hold;
    assign load   = avail & (~out_q | fire) & ~hold;
    assign cptr_n = cptr + PTR_W'(fire);

    always_ff @(posedge clk) begin
        if (hold) begin
            fptr  <= '0;
            cptr  <= '0;
            cgray <= '0;
            out_q <= 1'b0;
            dout  <= '0;
        end else begin
            if (load) begin
                dout <= mem_rdata;
                fptr <= fptr + PTR_W'(1);
            end
            out_q <= load | (out_q & ~fire);
            cptr  <= cptr_n;
            cgray <= cptr_n ^ (cptr_n >> 1);
        end
    end
endmodule

// File: rtl/dcfifo_fwft.sv
module dcfifo_fwft
    import dcfifo_pkg::*;
#(
    parameter int DATA_W   = 18,
    parameter int ADDR_W   = 6,
    parameter int ALMOST_N = 8
) (
    input  logic              rst,
    input  logic              wr_clk,
    input  logic              wr_en_hi,
    input  logic              wr_en_lo_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic              in_rdy,
    output logic              half_full,
    output logic              almost_flag,
    input  logic              rd_clk,
    input  logic              rd_en_n,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_rdy
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  w_ptr, w_gray, r_cptr, r_cgray;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] m_rdata;
    logic              w_en, r_avail, r_fire;
    wflags_t           w_flags;

    dcfifo_wr_ctrl #(.ADDR_W(ADDR_W), .ALMOST_N(ALMOST_N)) u_wr (
        .clk         (wr_clk),
        .rst         (rst),
        .we_hi       (wr_en_hi),
        .we_lo_n     (wr_en_lo_n),
        .rgray_async (r_cgray),
        .wptr        (w_ptr),
        .wgray       (w_gray),
        .wen         (w_en),
        .flags       (w_flags)
    );

    dcfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk (wr_clk),
        .we     (w_en),
        .waddr  (w_ptr[ADDR_W-1:0]),
        .wdata  (wr_data),
        .raddr  (r_addr),
        .rdata  (m_rdata)
    );

    dcfifo_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk         (rd_clk),
        .rst         (rst),
        .ren_n       (rd_en_n),
        .oe_a_n      (oe_a_n),
        .oe_b_n      (oe_b_n),
        .wgray_async (w_gray),
        .mem_rdata   (m_rdata),
        .raddr       (r_addr),
        .cptr        (r_cptr),
        .cgray       (r_cgray),
        .avail       (r_avail),
        .fire        (r_fire),
        .out_q       (out_rdy),
        .dout        (rd_data)
    );

    assign in_rdy      = w_flags.in_rdy;
    assign half_full   = w_flags.half_full;
    assign almost_flag = w_flags.almost;
endmodule

// File: rtl/dcfifo_fwft_chk.sv
module dcfifo_fwft_chk #(
    parameter int DATA_W = 18,
    parameter int PTR_W  = 7
) (
    input logic              rst,
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              wr_en_hi,
    input logic              wr_en_lo_n,
    input logic              in_rdy,
    input logic              half_full,
    input logic              almost_flag,
    input logic              rd_en_n,
    input logic              oe_a_n,
    input logic              oe_b_n,
    input logic              out_rdy,
    input logic [DATA_W-1:0] rd_data,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic [PTR_W-1:0]  rd_cptr,
    input logic              rd_avail
);
    // R1/R2: a full FIFO takes nothing.
    p_no_overflow_r1: assert property (@(posedge wr_clk) disable iff (rst)
        !in_rdy |=> $stable(wr_ptr));

    // R2: an unqualified write leaves the write pointer alone.
    p_write_qual_r2: assert property (@(posedge wr_clk) disable iff (rst)
        (!wr_en_hi || wr_en_lo_n) |=> $stable(wr_ptr));

    // R3: without all three low enables and a valid word, nothing is consumed.
    p_read_qual_r3: assert property (@(posedge rd_clk) disable iff (rst)
        !(out_rdy && !rd_en_n && !oe_a_n && !oe_b_n) |=> $stable(rd_cptr));

    // R4: an idle valid output holds its word.
    p_out_hold_r4: assert property (@(posedge rd_clk) disable iff (rst)
        (out_rdy && rd_en_n) |=> (out_rdy && $stable(rd_data)));

    // R4: a waiting word falls through on its own.
    p_fall_through_r4: assert property (@(posedge rd_clk) disable iff (rst)
        (!out_rdy && rd_avail) |=> out_rdy);

    // R7 and R8: reaching full implies both occupancy flags.
    p_full_flags_r7: assert property (@(posedge wr_clk) disable iff (rst)
        $fell(in_rdy) |-> (half_full && almost_flag));
endmodule

bind dcfifo_fwft dcfifo_fwft_chk #(.DATA_W(DATA_W), .PTR_W(ADDR_W + 1)) u_chk (
    .rst         (rst),
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .wr_en_hi    (wr_en_hi),
    .wr_en_lo_n  (wr_en_lo_n),
    .in_rdy      (in_rdy),
    .half_full   (half_full),
    .almost_flag (almost_flag),
    .rd_en_n     (rd_en_n),
    .oe_a_n      (oe_a_n),
    .oe_b_n      (oe_b_n),
    .out_rdy     (out_rdy),
    .rd_data     (rd_data),
    .wr_ptr      (w_ptr),
    .rd_cptr     (r_cptr),
    .rd_avail    (r_avail)
);

// File: tb/dcfifo_fwft_bench.sv
module dcfifo_fwft_bench;
    localparam int WR_PERIOD = 10;
    localparam int RD_PERIOD = 14;
    localparam int DW        = 18;
    localparam int DEPTH     = 64;
    localparam int NTH       = 8;

    logic          rst = 1'b1;
    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_en_hi = 1'b0;
    logic          wr_en_lo_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic          oe_a_n = 1'b1;
    logic          oe_b_n = 1'b1;
    logic          in_rdy, half_full, almost_flag, out_rdy;
    logic [DW-1:0] rd_data;

    int            checks = 0;
    int            fails  = 0;
    logic [DW-1:0] model[$];

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2) rd_clk = ~rd_clk;

    dcfifo_fwft #(.DATA_W(DW), .ADDR_W(6), .ALMOST_N(NTH)) u_dcfifo_fwft (
        .rst         (rst),
        .wr_clk      (wr_clk),
        .wr_en_hi    (wr_en_hi),
        .wr_en_lo_n  (wr_en_lo_n),
        .wr_data     (wr_data),
        .in_rdy      (in_rdy),
        .half_full   (half_full),
        .almost_flag (almost_flag),
        .rd_clk      (rd_clk),
        .rd_en_n     (rd_en_n),
        .oe_a_n      (oe_a_n),
        .oe_b_n      (oe_b_n),
        .rd_data     (rd_data),
        .out_rdy     (out_rdy)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_wr(input int n);
        repeat (n) @(negedge wr_clk);
    endtask

    task automatic wait_rd(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk);
        while (!in_rdy) @(negedge wr_clk);
        wr_en_hi   = 1'b1;
        wr_en_lo_n = 1'b0;
        wr_data    = d;
        @(negedge wr_clk);
        wr_en_hi   = 1'b0;
        wr_en_lo_n = 1'b1;
        model.push_back(d);
    endtask

    task automatic pop(input string req);
        logic [DW-1:0] exp;
        int k = 0;
        @(negedge rd_clk);
        while (!out_rdy && k < 40) begin
            @(negedge rd_clk);
            k++;
        end
        chk(req, "out_rdy before read", 32'(out_rdy), 32'd1);
        if (model.size() == 0) begin
            chk(req, "reference queue empty", 32'd0, 32'd1);
        end else begin
            exp = model.pop_front();
            chk(req, "rd_data order", 32'(rd_data), 32'(exp));
        end
        rd_en_n = 1'b0;
        oe_a_n  = 1'b0;
        oe_b_n  = 1'b0;
        @(negedge rd_clk);
        rd_en_n = 1'b1;
        oe_a_n  = 1'b1;
        oe_b_n  = 1'b1;
    endtask

    task automatic wait_out_rdy();
        int k = 0;
        while (!out_rdy && k < 40) begin
            @(negedge rd_clk);
            k++;
        end
    endtask

    // R5, R6: power-up reset with write attempts held during reset.
    task automatic t_reset();
        int k = 0;
        rst        = 1'b1;
        wr_en_hi   = 1'b1;
        wr_en_lo_n = 1'b0;
        wr_data    = 18'h2AAAA;
        wait_wr(8);
        chk("R5", "in_rdy in reset", 32'(in_rdy), 32'd0);
        chk("R5", "out_rdy in reset", 32'(out_rdy), 32'd0);
        chk("R5", "half_full in reset", 32'(half_full), 32'd0);
        chk("R5", "almost_flag in reset", 32'(almost_flag), 32'd1);
        rst        = 1'b0;
        wr_en_hi   = 1'b0;
        wr_en_lo_n = 1'b1;
        while (!in_rdy && k < 10) begin
            @(negedge wr_clk);
            k++;
        end
        chk("R6", "in_rdy rises within 4 wr edges", 32'(k <= 4), 32'd1);
        wait_rd(12);
        chk("R5", "no word accepted during reset", 32'(out_rdy), 32'd0);
    endtask

    // R2: enable combinations that must not write.
    task automatic t_write_qual();
        @(negedge wr_clk);
        wr_en_hi = 1'b0; wr_en_lo_n = 1'b0; wr_data = 18'h00011;
        wait_wr(3);
        wr_en_hi = 1'b1; wr_en_lo_n = 1'b1; wr_data = 18'h00022;
        wait_wr(3);
        wr_en_hi = 1'b0; wr_en_lo_n = 1'b1;
        wait_rd(12);
        chk("R2", "unqualified writes stored nothing", 32'(out_rdy), 32'd0);
        chk("R2", "count still zero", 32'(almost_flag), 32'd1);
    endtask

    // R4: fall-through with all read enables idle.
    task automatic t_fall_through();
        push(18'h15A5A);
        wait_out_rdy();
        chk("R4", "out_rdy without read", 32'(out_rdy), 32'd1);
        chk("R4", "first word presented", 32'(rd_data), 32'h15A5A);
        wait_rd(6);
        chk("R4", "word held while idle", 32'(rd_data), 32'h15A5A);
        chk("R4", "out_rdy held while idle", 32'(out_rdy), 32'd1);
    endtask

    // R3: partial enable sets do not consume.
    task automatic t_read_qual();
        push(18'h0C3C3);
        wait_rd(12);
        rd_en_n = 1'b0; oe_a_n = 1'b1; oe_b_n = 1'b0;
        wait_rd(3);
        chk("R3", "oe_a_n high blocks read", 32'(rd_data), 32'h15A5A);
        rd_en_n = 1'b0; oe_a_n = 1'b0; oe_b_n = 1'b1;
        wait_rd(3);
        chk("R3", "oe_b_n high blocks read", 32'(rd_data), 32'h15A5A);
        rd_en_n = 1'b1; oe_a_n = 1'b0; oe_b_n = 1'b0;
        wait_rd(3);
        chk("R3", "rd_en_n high blocks read", 32'(rd_data), 32'h15A5A);
        rd_en_n = 1'b1; oe_a_n = 1'b1; oe_b_n = 1'b1;
        pop("R3");
        pop("R3");
        wait_rd(4);
        chk("R3", "out_rdy falls after last read", 32'(out_rdy), 32'd0);
    endtask

    // R1, R7, R8, R9: fill to capacity with flag checks, then drain.
    task automatic t_fill();
        wait_wr(10);
        for (int i = 1; i <= DEPTH; i++) begin
            push(DW'(i * 18'h0911));
            chk("R7", $sformatf("half_full at %0d", i), 32'(half_full), 32'(i >= 33));
            chk("R8", $sformatf("almost_flag at %0d", i), 32'(almost_flag),
                32'((i <= NTH) || (i >= DEPTH - NTH)));
        end
        chk("R1", "in_rdy low when full", 32'(in_rdy), 32'd0);
        @(negedge wr_clk);
        wr_en_hi = 1'b1; wr_en_lo_n = 1'b0; wr_data = 18'h3FFFF;
        wait_wr(4);
        wr_en_hi = 1'b0; wr_en_lo_n = 1'b1;
        chk("R1", "in_rdy stays low", 32'(in_rdy), 32'd0);
        for (int i = 0; i < DEPTH; i++) pop("R9");
        wait_rd(6);
        chk("R1", "extra write was discarded", 32'(out_rdy), 32'd0);
        wait_wr(10);
        chk("R7", "half_full after drain", 32'(half_full), 32'd0);
        chk("R8", "almost_flag after drain", 32'(almost_flag), 32'd1);
        chk("R1", "in_rdy after drain", 32'(in_rdy), 32'd1);
    endtask

    // R9: simultaneous writes and reads on unrelated clocks.
    task automatic t_concurrent();
        for (int i = 0; i < 30; i++) push(DW'(18'h10000 + i));
        fork
            begin
                for (int i = 30; i < 70; i++) push(DW'(18'h10000 + i));
            end
            begin
                for (int i = 0; i < 70; i++) pop("R9");
            end
        join
        wait_rd(6);
        chk("R9", "empty after concurrent traffic", 32'(out_rdy), 32'd0);
        wait_wr(10);
        chk("R8", "almost_flag after concurrent drain", 32'(almost_flag), 32'd1);
    endtask

    // R5: reset in the middle of operation discards stored words.
    task automatic t_reset_midrun();
        for (int i = 0; i < 40; i++) push(DW'(18'h20000 + i));
        wait_wr(4);
        chk("R7", "half_full before mid-run reset", 32'(half_full), 32'd1);
        @(negedge wr_clk);
        rst = 1'b1;
        wait_wr(8);
        chk("R5", "half_full cleared in reset", 32'(half_full), 32'd0);
        chk("R5", "almost_flag set in reset", 32'(almost_flag), 32'd1);
        chk("R5", "out_rdy cleared in reset", 32'(out_rdy), 32'd0);
        rst = 1'b0;
        model.delete();
        wait_wr(6);
        wait_rd(10);
        chk("R5", "stored words discarded", 32'(out_rdy), 32'd0);
        chk("R6", "in_rdy back after reset", 32'(in_rdy), 32'd1);
    endtask

    initial begin
        t_reset();
        t_write_qual();
        t_fall_through();
        t_read_qual();
        t_fill();
        t_concurrent();
        t_reset_midrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(WR_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule